// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps the status of a parameterized number of interrupt lines. Each line has three bits: enable, pending and active. A request edge on a line is captured in the pending bit, and the bit stays set after the source lets go of the line. The pending bit is also written while the line is disabled, so a request that arrives early is held until the line is enabled. Software can set or clear pending bits through mask strobes, and it can load the whole enable vector in one write.

The core reports that it has started a handler with an entry strobe and an index, and that the handler has returned with an exit strobe and an index. The tracker turns these into active-bit updates. Its ready vector lists every line that is enabled, pending and not active, and a separate priority arbiter reads it. The request lines are asynchronous to the clock and pass through a two-stage synchronizer before edge detection.

Top module: `irq_state_tracker`

## Requirements
- R1: While rst_n is low, every bit of pend_o, act_o, en_o and ready_o is 0.
- R2: A 0-to-1 change on irq_req[i] sets pend_o[i] on the third rising clock edge after the change. The bit stays set after irq_req[i] drops.
- R3: ready_o[i] equals en_o[i] AND pend_o[i] AND NOT act_o[i]. A request on a disabled line still sets pend_o[i].
- R4: Several pulses on a line before its handler starts produce one pending request. After entry, pend_o[i] stays 0 when no further edge arrives.
- R5: On the edge where entry_vld is 1 with entry_idx=i, pend_o[i] clears and act_o[i] sets.
- R6: While act_o[i] is 1, ready_o[i] stays 0 even when pend_o[i] is 1. On the edge where exit_vld is 1 with exit_idx=i, act_o[i] clears and a set pend_o[i] makes ready_o[i] 1.
- R7: A request that goes low and then pulses again during the handler sets pend_o[i] again.
- R8: If the synchronized request is still high on the exit edge, pend_o[i] is set on that edge.
- R9: A 1 in bit i of sw_set_pend sets pend_o[i], and a 1 in bit i of sw_clr_pend clears it. Clearing before entry cancels the request.
- R10: A hardware set of pend_o[i] (an edge, or a held level at exit) beats a software clear or an entry clear in the same cycle. A software set also beats both clears.
- R11: When en_wr is 1, en_o is loaded with en_data on that edge. Otherwise en_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| irq_req | input | NUM_IRQ | Asynchronous interrupt request lines |
| sw_set_pend | input | NUM_IRQ | Software set-pending mask strobe |
| sw_clr_pend | input | NUM_IRQ | Software clear-pending mask strobe |
| en_wr | input | 1 | Enable vector write strobe |
| en_data | input | NUM_IRQ | Enable vector write data |
| entry_vld | input | 1 | Handler entry strobe |
| entry_idx | input | IDX_W | Index of the line being entered |
| exit_vld | input | 1 | Handler return strobe |
| exit_idx | input | IDX_W | Index of the line returning |
| pend_o | output | NUM_IRQ | Pending bits |
| act_o | output | NUM_IRQ | Active bits |
| en_o | output | NUM_IRQ | Enable bits |
| ready_o | output | NUM_IRQ | Lines that are enabled, pending and not active |

## Verification
All status bits are registered, so a wrong pending, active or enable bit shows on the outputs one cycle after the edge that produced it. Because ready_o is derived from those bits, the same error also shows there within that cycle. A lost or doubled request edge in the synchronizer shows three edges after the line changes, as a pend_o bit that differs from a behavioural model. That model is compared on every cycle, so no divergence can stay hidden for more than one clock. Directed sequences aim at the cases where two updates meet on one edge: an edge against a software clear, an edge against an entry, and a held level at exit.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  // status held for one interrupt line
  typedef struct packed {
    logic en;
    logic pend;
    logic act;
  } irq_slot_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_async,
  output logic [WIDTH-1:0] req_lvl,
  output logic [WIDTH-1:0] req_rise
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = req_async;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign req_lvl  = sync_q;
  assign req_rise = sync_q & ~prev_q;

  generate
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_chk
      // R2: a detected edge lasts exactly one cycle
      p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_rise[gi] |=> !req_rise[gi]);
    end
  endgenerate
endmodule

// File: rtl/irq_slot.sv
module irq_slot
  import irq_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_rise,
  input  logic req_lvl,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic en_we,
  input  logic en_d,
  input  logic entry_hit,
  input  logic exit_hit,
  output logic en,
  output logic pend,
  output logic act,
  output logic ready
);
  irq_slot_t st_q, st_d;
  logic hw_set;

  always_comb begin
    hw_set = req_rise | (exit_hit & req_lvl);
    st_d   = st_q;
    if (en_we) st_d.en = en_d;
    // set sources dominate every clear source
    st_d.pend = hw_set | sw_set | (st_q.pend & ~(sw_clr | entry_hit));
    if (entry_hit)     st_d.act = 1'b1;
    else if (exit_hit) st_d.act = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign en    = st_q.en;
  assign pend  = st_q.pend;
  assign act   = st_q.act;
  assign ready = st_q.en & st_q.pend & ~st_q.act;

  p_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_hit && !hw_set && !sw_set |=> act && !pend);
  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> pend);
  p_pend_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !sw_clr && !entry_hit |=> pend);
  p_exit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit && !entry_hit |=> !act);
  p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en));
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] sw_set_pend,
  input  logic [NUM_IRQ-1:0] sw_clr_pend,
  input  logic               en_wr,
  input  logic [NUM_IRQ-1:0] en_data,
  input  logic               entry_vld,
  input  logic [IDX_W-1:0]   entry_idx,
  input  logic               exit_vld,
  input  logic [IDX_W-1:0]   exit_idx,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] act_o,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [NUM_IRQ-1:0] ready_o
);
  logic [NUM_IRQ-1:0] lvl, rise, entry_hit, exit_hit;

  irq_req_sync #(.WIDTH(NUM_IRQ)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (irq_req),
    .req_lvl   (lvl),
    .req_rise  (rise)
  );

  generate
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_slot
      assign entry_hit[gi] = entry_vld && (entry_idx == IDX_W'(gi));
      assign exit_hit[gi]  = exit_vld  && (exit_idx  == IDX_W'(gi));

      irq_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rise  (rise[gi]),
        .req_lvl   (lvl[gi]),
        .sw_set    (sw_set_pend[gi]),
        .sw_clr    (sw_clr_pend[gi]),
        .en_we     (en_wr),
        .en_d      (en_data[gi]),
        .entry_hit (entry_hit[gi]),
        .exit_hit  (exit_hit[gi]),
        .en        (en_o[gi]),
        .pend      (pend_o[gi]),
        .act       (act_o[gi]),
        .ready     (ready_o[gi])
      );
    end
  endgenerate

  // R6: an active line never appears in the ready vector
  p_ready_not_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o & ready_o) == '0);
  // R5: one entry strobe activates at most one line
  p_entry_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_hit));
endmodule

// File: tb/irq_state_tracker_bench.sv
module irq_state_tracker_bench;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, sw_set_pend = '0, sw_clr_pend = '0, en_data = '0;
  logic en_wr = 1'b0, entry_vld = 1'b0, exit_vld = 1'b0;
  logic [IW-1:0] entry_idx = '0, exit_idx = '0;
  logic [N-1:0] pend_o, act_o, en_o, ready_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_state_tracker #(.NUM_IRQ(N)) u_irq_state_tracker (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .sw_set_pend(sw_set_pend), .sw_clr_pend(sw_clr_pend),
    .en_wr(en_wr), .en_data(en_data),
    .entry_vld(entry_vld), .entry_idx(entry_idx),
    .exit_vld(exit_vld), .exit_idx(exit_idx),
    .pend_o(pend_o), .act_o(act_o), .en_o(en_o), .ready_o(ready_o)
  );

  // behavioural reference: request history per line plus three status sets
  bit [N-1:0] h1, h2, h3, m_en, m_pend, m_act;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0; m_en = '0; m_pend = '0; m_act = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit ent, ext, hw;
        ent = entry_vld && (int'(entry_idx) == i);
        ext = exit_vld && (int'(exit_idx) == i);
        hw  = (h2[i] && !h3[i]) || (ext && h2[i]);
        if (hw || sw_set_pend[i]) m_pend[i] = 1'b1;
        else if (sw_clr_pend[i] || ent) m_pend[i] = 1'b0;
        if (ent) m_act[i] = 1'b1;
        else if (ext) m_act[i] = 1'b0;
      end
      if (en_wr) m_en = en_data;
      h3 = h2; h2 = h1; h1 = irq_req;
    end
  end

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R3 covers the ready rule)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model pend", pend_o, m_pend);
      check("R6 model act", act_o, m_act);
      check("R11 model en", en_o, m_en);
      check("R3 model ready", ready_o, m_en & m_pend & ~m_act);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic enter(int idx);
    entry_vld = 1'b1; entry_idx = IW'(idx); cyc(1); entry_vld = 1'b0;
  endtask
  task automatic leave(int idx);
    exit_vld = 1'b1; exit_idx = IW'(idx); cyc(1); exit_vld = 1'b0;
  endtask
  task automatic bitchk(string tag, logic a, logic e);
    check(tag, {{(N-1){1'b0}}, a}, {{(N-1){1'b0}}, e});
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    cyc(3);
    check("R1 reset pend", pend_o, '0);
    check("R1 reset act", act_o, '0);
    check("R1 reset en", en_o, '0);
    check("R1 reset ready", ready_o, '0);
    rst_n = 1'b1;
    cyc(2);

    // R2, R3: short pulse on a disabled line
    irq_req[0] = 1'b1; cyc(1); irq_req[0] = 1'b0; cyc(4);
    bitchk("R2 pend survives drop", pend_o[0], 1'b1);
    bitchk("R3 disabled not ready", ready_o[0], 1'b0);
    en_wr = 1'b1; en_data = 8'h05; cyc(1); en_wr = 1'b0;
    check("R11 enable load", en_o, 8'h05);
    bitchk("R3 ready after enable", ready_o[0], 1'b1);

    // R5: entry
    enter(0);
    bitchk("R5 entry clears pend", pend_o[0], 1'b0);
    bitchk("R5 entry sets act", act_o[0], 1'b1);

    // R7, R6: re-pulse during the handler, then exit
    irq_req[0] = 1'b1; cyc(1); irq_req[0] = 1'b0; cyc(4);
    bitchk("R7 repend in handler", pend_o[0], 1'b1);
    bitchk("R6 active blocks ready", ready_o[0], 1'b0);
    leave(0);
    bitchk("R6 exit clears act", act_o[0], 1'b0);
    bitchk("R6 ready after exit", ready_o[0], 1'b1);
    enter(0); leave(0);

    // R4: several pulses coalesce
    en_wr = 1'b1; en_data = 8'hFF; cyc(1); en_wr = 1'b0;
    repeat (3) begin irq_req[1] = 1'b1; cyc(1); irq_req[1] = 1'b0; cyc(1); end
    cyc(3);
    bitchk("R4 pend set once", pend_o[1], 1'b1);
    enter(1); cyc(4);
    bitchk("R4 no second request", pend_o[1], 1'b0);
    leave(1);
    bitchk("R4 not ready after exit", ready_o[1], 1'b0);

    // R8: held level re-pends at exit
    irq_req[2] = 1'b1; cyc(4);
    enter(2); cyc(2);
    bitchk("R8 held level no repend before exit", pend_o[2], 1'b0);
    leave(2);
    bitchk("R8 held level repends at exit", pend_o[2], 1'b1);
    irq_req[2] = 1'b0; cyc(3);
    enter(2); leave(2);
    bitchk("R8 dropped level no repend", pend_o[2], 1'b0);

    // R9: software set and cancel
    sw_set_pend = 8'h08; cyc(1); sw_set_pend = '0;
    bitchk("R9 sw set", ready_o[3], 1'b1);
    sw_clr_pend = 8'h08; cyc(1); sw_clr_pend = '0; cyc(3);
    bitchk("R9 sw clear cancels", pend_o[3], 1'b0);

    // R10: hardware edge against software clear, then against entry
    irq_req[5] = 1'b1; cyc(2);
    sw_clr_pend = 8'h20; cyc(1); sw_clr_pend = '0;
    bitchk("R10 edge beats sw clear", pend_o[5], 1'b1);
    irq_req[5] = 1'b0;
    sw_set_pend = 8'h40; cyc(1); sw_set_pend = '0;
    irq_req[6] = 1'b1; cyc(2);
    enter(6);
    bitchk("R10 edge beats entry clear", pend_o[6], 1'b1);
    bitchk("R10 entry still activates", act_o[6], 1'b1);
    irq_req[6] = 1'b0; leave(6); cyc(3);

    // mixed traffic checked by the model every cycle
    for (int k = 0; k < 400; k++) begin
      irq_req     = N'($urandom) & N'($urandom);
      sw_set_pend = (($urandom % 8) == 0) ? N'(1 << ($urandom % N)) : '0;
      sw_clr_pend = (($urandom % 8) == 0) ? N'(1 << ($urandom % N)) : '0;
      en_wr       = (($urandom % 16) == 0);
      en_data     = N'($urandom);
      entry_vld   = (($urandom % 4) == 0);
      entry_idx   = IW'($urandom);
      exit_vld    = (($urandom % 4) == 0);
      exit_idx    = IW'($urandom);
      cyc(1);
    end
    irq_req = '0; sw_set_pend = '0; sw_clr_pend = '0;
    en_wr = 1'b0; entry_vld = 1'b0; exit_vld = 1'b0;
    cyc(4);
    finish_run();
  end
endmodule